// File: doc/BRIEF.md
# External Interrupt Request Controller

This block gathers the external interrupt sources of a small 8-bit processor into one latched request. One dedicated pin is active low; up to four general port pins are active high and take part only when a build-time switch allows them. All sources are first brought into the clock domain and then merged into a single "some source is active" signal, and a pending flag is set when that merged signal goes from inactive to active. A second build-time switch adds level sensitivity, so that the flag keeps being set while any source stays active; this suits several open-drain sources wired onto one line.

Software sees one byte-wide register on a simple synchronous bus: an enable bit, a read-only pending flag and a write-one clear bit. The processor sees a request output that is raised only when the flag is pending, the enable bit is set and its own interrupt mask is clear; it pulses an acknowledge input while fetching the vector, which clears the flag so that a new event can be captured while the handler runs. The synchronized level of the dedicated pin is also brought out for pin-test branch instructions.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the register reads 0x80 (enable set, flag clear), the request output is 0 and the pin-level output is 1.
- R2: The merged active signal is true when the synchronized dedicated pin is 0 or, with port sources enabled, any synchronized port pin is 1; the flag is set on the clock edge on which the merged signal is active and was inactive one cycle earlier, which is the third rising clock edge after an input change.
- R3: In edge-only mode a source that stays active, or a change from one active combination to another, never sets the flag again; the merged signal must first return to inactive.
- R4: In edge-and-level mode the flag is set on every clock edge on which the merged signal is active, so a clear has no lasting effect while any source is active.
- R5: Register layout: bit 7 is the enable (read/write, reset 1); bit 3 is the pending flag (read-only, unaffected by writes to bit 3); writing 1 to bit 1 clears the flag; bits 6..4, 2, 1 and 0 always read 0.
- R6: The request output equals pending AND enable AND NOT cpuMask, evaluated combinationally from the current register state and mask input.
- R7: A one-cycle acknowledge pulse clears the flag on the next clock edge when no set condition occurs on that edge.
- R8: When a set condition falls on the same clock edge as a clear by acknowledge or by a write of bit 1, the flag ends up set.
- R9: With port sources disabled by the build-time switch, port pin activity never sets the flag.
- R10: The pin-level output follows the dedicated pin through a two-flop synchronizer, two clock edges after a change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irqPinN | input | 1 | Dedicated interrupt pin, active low |
| portPins | input | NPORT | Port pins usable as interrupt sources, active high |
| busSel | input | 1 | Bus access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Bus address, matched against REG_ADDR |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational, 0 when not reading this register |
| cpuMask | input | 1 | Processor interrupt mask, 1 = masked |
| vecAck | input | 1 | Vector fetch acknowledge pulse |
| irqReq | output | 1 | Interrupt request to the processor |
| irqPinLevel | output | 1 | Synchronized level of the dedicated pin |

## Verification
The set path and the two clear paths (acknowledge and register write) can land on the same clock edge. The bench changes a pin and then issues the clear exactly two cycles later so it meets the set on the third edge, and expects the flag to read 1 afterwards; the same clear one cycle later must leave the flag at 0. In level mode the same collision occurs every time a clear is written while a source is held, and the bench expects the flag to survive it throughout the full source-transition sweep.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int REG_W    = 8;
  localparam int BIT_EN   = 7;
  localparam int BIT_PEND = 3;
  localparam int BIT_CLR  = 1;

  typedef struct packed {
    logic enWrite;
    logic enValue;
    logic clrPend;
  } ctrl_strobe_t;
endpackage

// File: rtl/ext_irq_ctl.sv
module ext_irq_ctl
  import ext_irq_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h0C
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  input  logic              enFlag,
  input  logic              pendFlag,
  output ctrl_strobe_t      strb,
  output logic [REG_W-1:0]  busRdata
);
  logic hit;

  always_comb begin
    hit          = busSel && (busAddr == REG_ADDR);
    strb.enWrite = hit && busWr;
    strb.enValue = busWdata[BIT_EN];
    strb.clrPend = hit && busWr && busWdata[BIT_CLR];
    busRdata     = '0;
    if (hit && !busWr) begin
      busRdata[BIT_EN]   = enFlag;
      busRdata[BIT_PEND] = pendFlag;
    end
  end
endmodule

// File: rtl/ext_irq_dp.sv
module ext_irq_dp
  import ext_irq_pkg::*;
#(
  parameter int NPORT       = 4,
  parameter bit PORT_EN     = 1'b1,
  parameter bit LEVEL_TRIG  = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irqPinN,
  input  logic [NPORT-1:0] portPins,
  input  logic             vecAck,
  input  ctrl_strobe_t     strb,
  output logic             pendFlag,
  output logic             enFlag,
  output logic             setPend,
  output logic             pinLevel
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0]            pinSync;
  logic [SYNC_STAGES-1:0][NPORT-1:0] portSync;
  logic pinS, portAct, combAct, actPrev, edgeHit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pinSync  <= '1;
      portSync <= '0;
    end else begin
      pinSync[0]  <= irqPinN;
      portSync[0] <= portPins;
      for (int s = 1; s < SYNC_STAGES; s++) begin
        pinSync[s]  <= pinSync[s-1];
        portSync[s] <= portSync[s-1];
      end
    end
  end

  assign pinS = pinSync[LAST];

  generate
    if (PORT_EN) begin : g_ports
      assign portAct = |portSync[LAST];
    end else begin : g_noports
      assign portAct = 1'b0;
    end
  endgenerate

  always_comb begin
    combAct = !pinS || portAct;
    edgeHit = combAct && !actPrev;
    setPend = edgeHit || (LEVEL_TRIG && combAct);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      actPrev  <= 1'b0;
      pendFlag <= 1'b0;
      enFlag   <= 1'b1;
    end else begin
      actPrev <= combAct;
      if (setPend)
        pendFlag <= 1'b1;
      else if (vecAck || strb.clrPend)
        pendFlag <= 1'b0;
      if (strb.enWrite)
        enFlag <= strb.enValue;
    end
  end

  assign pinLevel = pinS;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int          NPORT       = 4,
  parameter bit          PORT_EN     = 1'b1,
  parameter bit          LEVEL_TRIG  = 1'b0,
  parameter int          SYNC_STAGES = 2,
  parameter int          ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irqPinN,
  input  logic [NPORT-1:0]  portPins,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic              cpuMask,
  input  logic              vecAck,
  output logic              irqReq,
  output logic              irqPinLevel
);
  ctrl_strobe_t strb;
  logic pendFlag, enFlag, setPend;

  ext_irq_ctl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_ctl (
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .enFlag(enFlag), .pendFlag(pendFlag), .strb(strb), .busRdata(busRdata)
  );

  ext_irq_dp #(
    .NPORT(NPORT), .PORT_EN(PORT_EN), .LEVEL_TRIG(LEVEL_TRIG),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .irqPinN(irqPinN), .portPins(portPins),
    .vecAck(vecAck), .strb(strb), .pendFlag(pendFlag), .enFlag(enFlag),
    .setPend(setPend), .pinLevel(irqPinLevel)
  );

  assign irqReq = pendFlag && enFlag && !cpuMask;
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpuMask,
  input logic       vecAck,
  input logic       irqReq,
  input logic [7:0] busRdata,
  input logic       pendFlag,
  input logic       setPend,
  input logic       clrPend
);
  a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cpuMask |-> !irqReq);

  a_r6_req_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irqReq |-> pendFlag);

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    setPend |=> pendFlag);

  a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (!setPend && (vecAck || clrPend)) |=> !pendFlag);

  a_r5_unused_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (busRdata & 8'h77) == 8'h00);
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpuMask(cpuMask), .vecAck(vecAck),
  .irqReq(irqReq), .busRdata(busRdata), .pendFlag(pendFlag),
  .setPend(setPend), .clrPend(strb.clrPend)
);

// File: tb/ext_irq_ctrl_bench.sv
module ext_irq_ctrl_bench;
  localparam logic [7:0] RA = 8'h0C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irqPinN = 1'b1;
  logic [3:0] portPins = 4'h0;
  logic busSel = 1'b0, busWr = 1'b0, cpuMask = 1'b0, vecAck = 1'b0;
  logic [7:0] busAddr = RA, busWdata = 8'h00;
  logic [7:0] rdE, rdL, rdN;
  logic reqE, reqL, reqN, lvlE, lvlL, lvlN;
  int nTests = 0, nFail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ext_irq_ctrl #(.LEVEL_TRIG(1'b0), .PORT_EN(1'b1), .REG_ADDR(RA)) u_ext_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irqPinN(irqPinN), .portPins(portPins),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(rdE), .cpuMask(cpuMask), .vecAck(vecAck), .irqReq(reqE),
    .irqPinLevel(lvlE));

  ext_irq_ctrl #(.LEVEL_TRIG(1'b1), .PORT_EN(1'b1), .REG_ADDR(RA)) u_ext_irq_ctrl_lvl (
    .clk(clk), .rst_n(rst_n), .irqPinN(irqPinN), .portPins(portPins),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(rdL), .cpuMask(cpuMask), .vecAck(vecAck), .irqReq(reqL),
    .irqPinLevel(lvlL));

  ext_irq_ctrl #(.LEVEL_TRIG(1'b0), .PORT_EN(1'b0), .REG_ADDR(RA)) u_ext_irq_ctrl_nop (
    .clk(clk), .rst_n(rst_n), .irqPinN(irqPinN), .portPins(portPins),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(rdN), .cpuMask(cpuMask), .vecAck(vecAck), .irqReq(reqN),
    .irqPinLevel(lvlN));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic [4:0] src);
    irqPinN  = src[4];
    portPins = src[3:0];
  endtask

  function automatic bit actAll(input logic [4:0] s);
    return !s[4] || (s[3:0] != 4'h0);
  endfunction

  function automatic bit actPin(input logic [4:0] s);
    return !s[4];
  endfunction

  task automatic regWrite(input logic [7:0] d);
    busSel = 1'b1; busWr = 1'b1; busWdata = d;
    waitN(1);
    busSel = 1'b0; busWr = 1'b0; busWdata = 8'h00;
  endtask

  task automatic readAll();
    busSel = 1'b1; busWr = 1'b0;
    #1;
  endtask

  task automatic readEnd();
    busSel = 1'b0;
  endtask

  initial begin
    waitN(3);
    rst_n = 1'b1;
    waitN(1);
    readAll();
    chk("R1 reg edge", rdE, 8'h80);
    chk("R1 reg level", rdL, 8'h80);
    chk("R1 reg noport", rdN, 8'h80);
    readEnd();
    chk("R1 req", {5'b0, reqE, reqL, reqN}, 8'h00);
    chk("R1 pin level", {5'b0, lvlE, lvlL, lvlN}, 8'h07);

    // R2 R3 R4 R9 R10: sweep every pair of source states
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 32; b++) begin
        drive(a[4:0]);
        waitN(4);
        regWrite(8'h82);
        drive(b[4:0]);
        waitN(4);
        readAll();
        chk("R2 R3 edge sweep", rdE, {1'b1, 3'b0, actAll(b[4:0]) && !actAll(a[4:0]), 3'b0});
        chk("R4 level sweep", rdL, {1'b1, 3'b0, actAll(b[4:0]) || actAll(a[4:0]), 3'b0});
        chk("R9 noport sweep", rdN, {1'b1, 3'b0, actPin(b[4:0]) && !actPin(a[4:0]), 3'b0});
        readEnd();
        chk("R10 pin level", {7'b0, lvlE}, {7'b0, b[4]});
      end
    end

    // R6: request gating over enable, pending, mask
    for (int e = 0; e < 2; e++) begin
      for (int p = 0; p < 2; p++) begin
        for (int m = 0; m < 2; m++) begin
          drive(5'h10);
          cpuMask = 1'b0;
          waitN(4);
          regWrite({e[0], 5'b0, 1'b1, 1'b0});
          if (p != 0) begin
            drive(5'h00); waitN(4); drive(5'h10); waitN(4);
          end
          cpuMask = m[0];
          #1;
          chk("R6 request gate", {7'b0, reqE}, {7'b0, e[0] && p[0] && !m[0]});
          waitN(1);
        end
      end
    end
    cpuMask = 1'b0;

    // R7: acknowledge clears
    drive(5'h10); waitN(4); regWrite(8'h82);
    drive(5'h01); waitN(4);
    readAll(); chk("R7 pending before ack", rdE, 8'h88); readEnd();
    vecAck = 1'b1; waitN(1); vecAck = 1'b0;
    readAll(); chk("R7 ack clears", rdE, 8'h80); readEnd();

    // R5: register field behaviour
    drive(5'h10); waitN(4); regWrite(8'h82);
    drive(5'h00); waitN(4); drive(5'h10); waitN(4);
    regWrite(8'h08);
    readAll(); chk("R5 bit3 write keeps flag, enable off", rdE, 8'h08); readEnd();
    regWrite(8'h75);
    readAll(); chk("R5 write without bit1 keeps flag", rdE, 8'h08); readEnd();
    regWrite(8'hFF);
    readAll(); chk("R5 all-ones write", rdE, 8'h80); readEnd();
    regWrite(8'h08);
    readAll(); chk("R5 bit3 write cannot set", rdE, 8'h00); readEnd();
    regWrite(8'h80);

    // R8: set meets register clear on the same edge
    drive(5'h10); waitN(4); regWrite(8'h82);
    drive(5'h00); waitN(2);
    busSel = 1'b1; busWr = 1'b1; busWdata = 8'h82;
    waitN(1);
    busSel = 1'b0; busWr = 1'b0;
    readAll(); chk("R8 set beats write clear", rdE, 8'h88); readEnd();

    // R8: set meets acknowledge on the same edge
    drive(5'h10); waitN(4); regWrite(8'h82);
    drive(5'h00); waitN(2);
    vecAck = 1'b1; waitN(1); vecAck = 1'b0;
    readAll(); chk("R8 set beats ack", rdE, 8'h88); readEnd();

    // R2 timing: clear one edge after the set takes effect
    drive(5'h10); waitN(4); regWrite(8'h82);
    drive(5'h00); waitN(3);
    regWrite(8'h82);
    readAll(); chk("R2 clear after set edge", rdE, 8'h80); readEnd();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule